// File: doc/BRIEF.md
# Sixteen-Phase PSK Symbol Mapper

This block converts short groups of data bits into complex baseband samples for an interpolating filter that follows it. Each symbol strobe carries two or three bits. The block maps them onto one of sixteen phase points spaced 22.5 degrees apart. It emits a registered 32-bit word with the in-phase part in the upper half and the quadrature part in the lower half. The filter downstream handles this word as if it had come straight from the serial input.

Three modulations are supported: pi/4-DQPSK, plain 8-PSK and 8-PSK with a 3pi/8 rotation on every symbol. The two differential or rotating modes share one 4-bit phase index, which wraps modulo sixteen. All output amplitudes come from four programmable unsigned magnitudes, each giving the cosine at 0, 22.5, 45 and 67.5 degrees. Quadrant symmetry supplies every other value.

When the global extension enable is low, or the mode code is not one of the three, the block does not map. It passes a bypass word through instead. A synchronous clear input returns the phase index to zero.

Top module: `psk16_mapper`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it, `out_valid` is 0, `out_word` is 0 and the phase index is 0.
- R2: `out_valid` is high in the cycle after each clock edge where `sym_valid` was sampled high, and low after every other edge.
- R3: `out_word` holds its value across every edge where `sym_valid` is low.
- R4: With mode code 3'b001 (pi/4-DQPSK), `sym_bits[1:0]` advances the phase index modulo 16 as follows: 00 by +2, 01 by +6, 11 by +10 (that is, -6), 10 by +14 (that is, -2). The output uses the updated index.
- R5: With mode code 3'b101 (8-PSK), the output index is twice the Gray-decoded value of `sym_bits[2:0]`, using the Gray order 000,001,011,010,110,111,101,100 for the values 0..7. The phase index is left unchanged.
- R6: With mode code 3'b110 (3pi/8-8PSK), every symbol adds 3 to the phase index modulo 16. The output index is the new phase index plus twice the Gray-decoded value, modulo 16.
- R7: For output index p, I equals cos(p·22.5°) and Q equals sin(p·22.5°). The cosine at k·22.5° (k=0..3) is magnitude k from `mag_set[16k+15:16k]`, and the cosine at 90° is 0. Negative values are two's complement modulo 2^16. The word is {I, Q}, with I in bits 31:16.
- R8: When `ext_en` is low, or the mode code is any other value, a strobe loads `bypass_word` into `out_word` and leaves the phase index unchanged.
- R9: `phase_clr` sets the phase index to 0 at the next edge. A strobe in the same cycle is computed from a phase of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_en | input | 1 | Global extension enable; low selects bypass |
| mode | input | 3 | Modulation code |
| sym_valid | input | 1 | Symbol strobe |
| sym_bits | input | 3 | Symbol data bits |
| phase_clr | input | 1 | Synchronous clear of the phase index |
| mag_set | input | 64 | Four 16-bit unsigned magnitudes, index k in bits 16k+15:16k |
| bypass_word | input | 32 | Word passed through when mapping is inactive |
| out_word | output | 32 | {I, Q} output sample |
| out_valid | output | 1 | One-cycle output strobe |

## Verification
A corrupted phase index does not show at once in 8-PSK, where the index is bypassed. It appears in the first differential or rotated symbol that follows, as a constant phase offset in every later output word. A wrong quadrant fold or magnitude choice shows in the very output word of the affected index. So the bench sweeps all sixteen indices and compares every word in the cycle after its strobe. A missed phase update is caught one symbol later.

// File: rtl/psk16_pkg.sv
// Package: shared constants and small pure functions for the PSK mapper.
// Assumes a fixed circle of sixteen phase points.
package psk16_pkg;
    localparam int PHASES = 16;
    localparam int IDX_W  = $clog2(PHASES);

    localparam logic [2:0] MODE_DQPSK   = 3'b001;
    localparam logic [2:0] MODE_8PSK    = 3'b101;
    localparam logic [2:0] MODE_8PSK_RT = 3'b110;

    // Convert a 3-bit Gray code to its binary position on the circle.
    function automatic logic [2:0] gray3_to_bin(input logic [2:0] g);
        logic [2:0] b;
        b[2] = g[2];
        b[1] = b[2] ^ g[1];
        b[0] = b[1] ^ g[0];
        return b;
    endfunction

    // Phase step for one pi/4-DQPSK dibit, in units of 22.5 degrees.
    function automatic logic [IDX_W-1:0] dqpsk_step(input logic [1:0] d);
        case (d)
            2'b00:   return IDX_W'(2);
            2'b01:   return IDX_W'(6);
            2'b11:   return IDX_W'(10);
            default: return IDX_W'(14);
        endcase
    endfunction
endpackage

// File: rtl/psk16_phase.sv
// Phase tracker: holds the shared phase index and derives the output index
// for the current symbol. Assumes the mode code is stable while sym_valid is high.
module psk16_phase
    import psk16_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_en,
    input  logic [2:0]       mode,
    input  logic             sym_valid,
    input  logic [2:0]       sym_bits,
    input  logic             phase_clr,
    output logic             map_en,
    output logic [IDX_W-1:0] out_idx,
    output logic [IDX_W-1:0] phase_q
);
    localparam logic [IDX_W-1:0] ROT_STEP = IDX_W'(3);

    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] nxt;
    logic [IDX_W-1:0] pt8;

    // Decide whether this mode code is one the mapper serves.
    always_comb begin
        map_en = ext_en && (mode == MODE_DQPSK || mode == MODE_8PSK || mode == MODE_8PSK_RT);
    end

    // Compute next phase and output index for the present symbol.
    always_comb begin
        base    = phase_clr ? '0 : phase_q;
        pt8     = {gray3_to_bin(sym_bits), 1'b0};
        nxt     = base;
        out_idx = base;
        case (mode)
            MODE_DQPSK: begin
                nxt     = base + dqpsk_step(sym_bits[1:0]);
                out_idx = nxt;
            end
            MODE_8PSK: begin
                out_idx = pt8;
            end
            MODE_8PSK_RT: begin
                nxt     = base + ROT_STEP;
                out_idx = nxt + pt8;
            end
            default: begin
                out_idx = base;
            end
        endcase
    end

    // Hold the phase index across symbols; clear or advance on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (sym_valid && map_en)
            phase_q <= nxt;
        else if (phase_clr)
            phase_q <= '0;
    end
endmodule

// File: rtl/psk16_iq.sv
// Quadrant fold: builds I and Q for any of sixteen phases from four stored
// cosine magnitudes. Assumes magnitude k is cos(k*22.5 deg) scaled; results wrap.
module psk16_iq
    import psk16_pkg::*;
#(
    parameter int MAG_W = 16,
    parameter int NMAG  = PHASES / 4
) (
    input  logic [IDX_W-1:0]      idx,
    input  logic [NMAG*MAG_W-1:0] mag_set,
    output logic [MAG_W-1:0]      i_val,
    output logic [MAG_W-1:0]      q_val
);
    localparam int SUB_W = $clog2(NMAG);

    logic [MAG_W-1:0] mag [NMAG];
    logic [SUB_W-1:0] sub;
    logic [1:0]       quad;
    logic [MAG_W-1:0] c_val;
    logic [MAG_W-1:0] s_val;

    // Unpack the magnitude bus into an array.
    for (genvar k = 0; k < NMAG; k++) begin : g_unpack
        assign mag[k] = mag_set[k*MAG_W +: MAG_W];
    end

    // First-quadrant cosine and sine, then rotate into the real quadrant.
    always_comb begin
        sub   = idx[SUB_W-1:0];
        quad  = idx[IDX_W-1 -: 2];
        c_val = mag[sub];
        s_val = (sub == '0) ? '0 : mag[SUB_W'(0) - sub];
        case (quad)
            2'd0:    begin i_val = c_val;  q_val = s_val;  end
            2'd1:    begin i_val = -s_val; q_val = c_val;  end
            2'd2:    begin i_val = -c_val; q_val = -s_val; end
            default: begin i_val = s_val;  q_val = -c_val; end
        endcase
    end
endmodule

// File: rtl/psk16_mapper.sv
// Top: sixteen-phase PSK symbol mapper with registered {I,Q} output and
// bypass when the extension enable is low. Assumes one symbol per strobe.
module psk16_mapper
    import psk16_pkg::*;
#(
    parameter int MAG_W  = 16,
    parameter int NMAG   = PHASES / 4,
    parameter int WORD_W = 2 * MAG_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ext_en,
    input  logic [2:0]            mode,
    input  logic                  sym_valid,
    input  logic [2:0]            sym_bits,
    input  logic                  phase_clr,
    input  logic [NMAG*MAG_W-1:0] mag_set,
    input  logic [WORD_W-1:0]     bypass_word,
    output logic [WORD_W-1:0]     out_word,
    output logic                  out_valid
);
    logic             map_en;
    logic [IDX_W-1:0] out_idx;
    logic [IDX_W-1:0] phase_q;
    logic [MAG_W-1:0] i_val;
    logic [MAG_W-1:0] q_val;

    psk16_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_en    (ext_en),
        .mode      (mode),
        .sym_valid (sym_valid),
        .sym_bits  (sym_bits),
        .phase_clr (phase_clr),
        .map_en    (map_en),
        .out_idx   (out_idx),
        .phase_q   (phase_q)
    );

    psk16_iq #(.MAG_W(MAG_W), .NMAG(NMAG)) u_iq (
        .idx     (out_idx),
        .mag_set (mag_set),
        .i_val   (i_val),
        .q_val   (q_val)
    );

    // Register the output word and the one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= sym_valid;
            if (sym_valid)
                out_word <= map_en ? {i_val, q_val} : bypass_word;
        end
    end
endmodule

// File: rtl/psk16_chk.sv
// Checker: temporal properties of the PSK mapper, bound to the top module.
// Assumes the default magnitude width of the top.
module psk16_chk #(
    parameter int MAG_W  = 16,
    parameter int WORD_W = 2 * MAG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_en,
    input logic [2:0]        mode,
    input logic              sym_valid,
    input logic [2:0]        sym_bits,
    input logic              phase_clr,
    input logic [4*MAG_W-1:0] mag_set,
    input logic [WORD_W-1:0] bypass_word,
    input logic [WORD_W-1:0] out_word,
    input logic              out_valid,
    input logic [3:0]        phase_q
);
    // R2
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> out_valid);
    // R2
    valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> !out_valid);
    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(out_word));
    // R8
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !ext_en) |=> out_word == $past(bypass_word));
    // R8
    bypass_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !ext_en && !phase_clr) |=> $stable(phase_q));
    // R4
    dqpsk_even_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && ext_en && mode == 3'b001 && !phase_clr) |=> phase_q[0] == $past(phase_q[0]));
    // R5
    psk8_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && ext_en && mode == 3'b101 && sym_bits == 3'b000)
        |=> out_word == {$past(mag_set[MAG_W-1:0]), {MAG_W{1'b0}}});
    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_clr && !sym_valid) |=> phase_q == 4'd0);
endmodule

bind psk16_mapper psk16_chk #(.MAG_W(MAG_W), .WORD_W(WORD_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .mode(mode),
    .sym_valid(sym_valid), .sym_bits(sym_bits), .phase_clr(phase_clr),
    .mag_set(mag_set), .bypass_word(bypass_word), .out_word(out_word),
    .out_valid(out_valid), .phase_q(phase_q)
);

// File: tb/test_psk16_mapper.sv
`timescale 1ns/1ps
module test_psk16_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_en = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic        sym_valid = 1'b0;
    logic [2:0]  sym_bits = 3'b000;
    logic        phase_clr = 1'b0;
    logic [63:0] mag_set = '0;
    logic [31:0] bypass_word = '0;
    logic [31:0] out_word;
    logic        out_valid;

    int n_cmp = 0;
    int n_bad = 0;
    string seg = "";

    // reference state
    int          ref_phase = 0;
    logic [31:0] ref_word = '0;
    logic        ref_valid = 1'b0;
    string       ref_tag = "R1";

    always #2.5 clk = ~clk;

    psk16_mapper i_psk16_mapper (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .mode(mode),
        .sym_valid(sym_valid), .sym_bits(sym_bits), .phase_clr(phase_clr),
        .mag_set(mag_set), .bypass_word(bypass_word),
        .out_word(out_word), .out_valid(out_valid)
    );

    function automatic int gray_pos(input logic [2:0] g);
        logic [2:0] order [8] = '{3'b000, 3'b001, 3'b011, 3'b010, 3'b110, 3'b111, 3'b101, 3'b100};
        for (int k = 0; k < 8; k++) if (order[k] == g) return k;
        return 0;
    endfunction

    function automatic int cos_at(input int p);
        int a = ((p % 16) + 16) % 16;
        if (a > 8) a = 16 - a;
        if (a == 4) return 0;
        if (a < 4) return int'(mag_set[a*16 +: 16]);
        return -int'(mag_set[(8-a)*16 +: 16]);
    endfunction

    function automatic logic [31:0] iq_word(input int p);
        logic [15:0] iv = 16'(cos_at(p));
        logic [15:0] qv = 16'(cos_at(p - 4));
        return {iv, qv};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model updated at each edge and compared shortly after.
    always @(posedge clk) begin
        int delta;
        int p;
        if (!rst_n) begin
            ref_phase = 0; ref_word = '0; ref_valid = 1'b0; ref_tag = "R1";
        end else begin
            ref_valid = sym_valid;
            ref_tag = "R3";
            if (phase_clr) ref_phase = 0;
            if (sym_valid) begin
                if (ext_en && mode == 3'b001) begin
                    case (sym_bits[1:0])
                        2'b00: delta = 2;
                        2'b01: delta = 6;
                        2'b11: delta = -6;
                        default: delta = -2;
                    endcase
                    ref_phase = (ref_phase + delta + 16) % 16;
                    ref_word = iq_word(ref_phase);
                    ref_tag = "R4";
                end else if (ext_en && mode == 3'b101) begin
                    ref_word = iq_word(2 * gray_pos(sym_bits));
                    ref_tag = "R5";
                end else if (ext_en && mode == 3'b110) begin
                    ref_phase = (ref_phase + 3) % 16;
                    p = ref_phase + 2 * gray_pos(sym_bits);
                    ref_word = iq_word(p);
                    ref_tag = "R6";
                end else begin
                    ref_word = bypass_word;
                    ref_tag = "R8";
                end
            end
            if (phase_clr) ref_tag = "R9";
            if (seg != "") ref_tag = seg;
        end
        #1;
        check("R2 valid", {31'b0, out_valid}, {31'b0, ref_valid});
        check(ref_tag, out_word, ref_word);
    end

    task automatic send(input logic [2:0] m, input logic [2:0] b);
        @(negedge clk);
        mode = m; sym_bits = b; sym_valid = 1'b1; phase_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            sym_valid = 1'b0; phase_clr = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        mag_set = {16'd12539, 16'd23170, 16'd30274, 16'd32767};
        bypass_word = 32'hA5A5_0F0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: nothing produced straight after reset
        check("R1 word", out_word, 32'h0);
        check("R1 valid", {31'b0, out_valid}, 32'h0);
        ext_en = 1'b1;
        // R4: every dibit, back to back and with gaps
        for (int k = 0; k < 12; k++) send(3'b001, 3'(k % 4));
        idle(3);
        for (int k = 0; k < 8; k++) begin send(3'b001, 3'((k * 3) % 4)); idle(1); end
        // R5: all eight Gray codes
        for (int k = 0; k < 8; k++) send(3'b101, 3'(k));
        idle(2);
        // R6: rotated 8-PSK sweeps, then DQPSK on top of the shared phase
        for (int k = 0; k < 16; k++) send(3'b110, 3'((k * 5) % 8));
        send(3'b001, 3'b01);
        idle(2);
        // R7: asymmetric magnitudes over all sixteen indices, including 0x8000
        seg = "R7";
        mag_set = {16'h0123, 16'h4567, 16'h8000, 16'h7FFF};
        for (int k = 0; k < 8; k++) send(3'b101, 3'(k));
        for (int k = 0; k < 16; k++) send(3'b110, 3'(k % 8));
        idle(1);
        seg = "";
        // R8: bypass when disabled and for an unserved mode code
        ext_en = 1'b0;
        bypass_word = 32'h1234_5678;
        send(3'b001, 3'b011);
        bypass_word = 32'hDEAD_BEEF;
        send(3'b110, 3'b001);
        idle(1);
        ext_en = 1'b1;
        send(3'b000, 3'b010);
        send(3'b111, 3'b010);
        send(3'b001, 3'b000);
        idle(2);
        // R9: clear alone, then clear together with a strobe
        @(negedge clk); phase_clr = 1'b1; sym_valid = 1'b0;
        idle(1);
        send(3'b001, 3'b01);
        send(3'b110, 3'b000);
        @(negedge clk); phase_clr = 1'b1; sym_valid = 1'b1; mode = 3'b110; sym_bits = 3'b011;
        idle(1);
        send(3'b001, 3'b11);
        @(negedge clk); phase_clr = 1'b1; sym_valid = 1'b1; mode = 3'b001; sym_bits = 3'b10;
        idle(3);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule